// File: doc/BRIEF.md
# DSD Bitstream Receiver with Monophase and Biphase Framing

This block takes a one-bit direct stream digital input and turns it into recovered bits, each marked by a one-cycle valid strobe. All logic runs on one fast system clock. The 64fs frame clock and the 128fs bit clock arrive as ordinary inputs that are already synchronous to it, and the block finds their edges by comparing each input with its value on the previous cycle.

Two pins together decide whether stream mode is active. While it is active, the recovered bits go straight out with no filtering. A third pin picks the framing. In monophase framing, one bit is taken at each rising edge of the frame clock. In biphase framing, the data is Manchester coded and two samples are taken per cell, both on falling edges of the bit clock. The sample taken while the frame clock is high is the first half-cell. The sample taken while the frame clock is low is the second half-cell, and it gives the bit value. If the two halves are equal, a sticky error flag is raised.

Top module: `dsd_bit_receiver`

## Requirements
- R1: Stream mode is active only when `mode_sel` is 0 and `dsd_req` is 1. In every other case `bit_vld` and `bit_out` are 0 in that same cycle.
- R2: In monophase framing (`fmt_bi` = 0), a clock edge where `dsd_clk` is 1 and was 0 on the previous edge captures `din`. `bit_vld` is then 1 for exactly the following cycle, and `bit_out` equals the captured value.
- R3: In biphase framing (`fmt_bi` = 1), a fall of `bit_clk` (1 on the previous edge, 0 now) while `dsd_clk` is 1 stores the first half-cell. A fall of `bit_clk` while `dsd_clk` is 0 decodes the cell, but only if a first half is stored. `bit_vld` is then 1 for the following cycle, with `bit_out` equal to `din` at that edge.
- R4: When a biphase cell is decoded and both half-cell samples are equal, `code_err` goes to 1. It stays at 1 until the decoder state is cleared.
- R5: A change of `fmt_bi` clears the decoder state: the stored first half and `code_err`.
- R6: Leaving stream mode clears the decoder state, so a cell whose first half came before the exit produces no strobe.
- R7: With steady clocks, exactly one `bit_vld` pulse occurs per 64fs period in either framing, and no pulse is longer than one cycle.
- R8: After reset, `bit_vld`, `bit_out` and `code_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 1 | Must be 0 for stream mode |
| dsd_req | input | 1 | Must be 1 for stream mode |
| fmt_bi | input | 1 | Framing select: 0 monophase, 1 biphase |
| dsd_clk | input | 1 | 64fs frame clock level |
| bit_clk | input | 1 | 128fs bit clock level |
| din | input | 1 | Serial stream data |
| bit_out | output | 1 | Recovered bit |
| bit_vld | output | 1 | One-cycle strobe for `bit_out` |
| code_err | output | 1 | Sticky biphase coding error |

## Verification
The hardest case to reach from the ports is a biphase cell whose first half was stored, but whose decoding edge comes after the decoder was cleared. The bench builds it by dropping `dsd_req` for a single system cycle between the two half-cell samples of one cell, then checks that no strobe follows. Coding errors are made by holding `din` constant across a whole cell, and they are cleared by a one-cycle detour through the other framing.

// File: rtl/dsd_bit_receiver.sv
module dsd_bit_receiver (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_sel,
  input  logic dsd_req,
  input  logic fmt_bi,
  input  logic dsd_clk,
  input  logic bit_clk,
  input  logic din,
  output logic bit_out,
  output logic bit_vld,
  output logic code_err
);
  logic dclk_q, bclk_q, fmt_q;
  logic half_ok, half_val;
  logic bit_r, vld_r, err_r;

  wire dsd_on = !mode_sel && dsd_req;
  wire clr    = !dsd_on || (fmt_bi != fmt_q);
  wire d_rise = dsd_clk && !dclk_q;
  wire b_fall = !bit_clk && bclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dclk_q   <= 1'b0;
      bclk_q   <= 1'b0;
      fmt_q    <= 1'b0;
      half_ok  <= 1'b0;
      half_val <= 1'b0;
      bit_r    <= 1'b0;
      vld_r    <= 1'b0;
      err_r    <= 1'b0;
    end else begin
      dclk_q <= dsd_clk;
      bclk_q <= bit_clk;
      fmt_q  <= fmt_bi;
      vld_r  <= 1'b0;
      if (clr) begin
        half_ok <= 1'b0;
        err_r   <= 1'b0;
        bit_r   <= 1'b0;
      end else if (!fmt_bi) begin
        if (d_rise) begin
          bit_r <= din;
          vld_r <= 1'b1;
        end
      end else if (b_fall) begin
        if (dsd_clk) begin
          half_val <= din;
          half_ok  <= 1'b1;
        end else if (half_ok) begin
          bit_r   <= din;
          vld_r   <= 1'b1;
          half_ok <= 1'b0;
          if (din == half_val) err_r <= 1'b1;
        end
      end
    end
  end

  assign bit_out  = dsd_on && bit_r;
  assign bit_vld  = dsd_on && vld_r;
  assign code_err = err_r;
endmodule

// File: rtl/dsd_bit_receiver_chk.sv
module dsd_bit_receiver_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_sel,
  input logic dsd_req,
  input logic fmt_bi,
  input logic dsd_clk,
  input logic bit_clk,
  input logic bit_out,
  input logic bit_vld,
  input logic code_err
);
  wire on = !mode_sel && dsd_req;

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !on |-> (!bit_vld && !bit_out)); // R1

  AST_MONO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (on && !fmt_bi && !$past(fmt_bi) && dsd_clk && !$past(dsd_clk)) |=> (bit_vld || !(!mode_sel && dsd_req))); // R2

  AST_BI_STROBE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && $past(fmt_bi)) |-> ($past(bit_clk, 2) && !$past(bit_clk) && !$past(dsd_clk))); // R3

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (code_err && on && fmt_bi == $past(fmt_bi)) |=> code_err); // R4

  AST_ERR_CLEAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> !code_err); // R6

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> !bit_vld); // R7
endmodule

bind dsd_bit_receiver dsd_bit_receiver_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .dsd_req(dsd_req),
  .fmt_bi(fmt_bi), .dsd_clk(dsd_clk), .bit_clk(bit_clk),
  .bit_out(bit_out), .bit_vld(bit_vld), .code_err(code_err)
);

// File: tb/dsd_bit_receiver_bench.sv
`timescale 1ns/1ps
module dsd_bit_receiver_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sel = 1'b0, dsd_req = 1'b1, fmt_bi = 1'b0;
  logic dsd_clk = 1'b0, bit_clk = 1'b0, din = 1'b0;
  logic bit_out, bit_vld, code_err;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  bit m_half_ok = 1'b0, m_half = 1'b0, m_err = 1'b0;

  always #5 clk = ~clk;

  dsd_bit_receiver u_dsd_bit_receiver (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .dsd_req(dsd_req),
    .fmt_bi(fmt_bi), .dsd_clk(dsd_clk), .bit_clk(bit_clk), .din(din),
    .bit_out(bit_out), .bit_vld(bit_vld), .code_err(code_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One 64fs period = 8 system cycles; bit_clk falls at i=2 (dsd_clk high) and i=6 (dsd_clk low).
  // drop: cycle index at which stream mode is left for one cycle (-1: never).
  // bad: hold din constant over the biphase cell.
  task automatic period(input bit b, input int drop, input bit bad, input string req);
    int nv = 0;
    for (int i = 0; i < 8; i++) begin
      bit on, ev, dv;
      @(negedge clk);
      on = (i != drop);
      dsd_req  = on;
      dsd_clk  = (i < 4);
      bit_clk  = ((i % 4) < 2);
      dv = (fmt_bi && !bad && i < 4) ? !b : b;
      din = dv;
      ev = 1'b0;
      if (!on) begin
        m_half_ok = 1'b0; m_err = 1'b0;
      end else if (!fmt_bi) begin
        ev = (i == 0);
      end else if (i == 2) begin
        m_half = dv; m_half_ok = 1'b1;
      end else if (i == 6 && m_half_ok) begin
        ev = 1'b1; m_half_ok = 1'b0;
        if (m_half == dv) m_err = 1'b1;
      end
      @(posedge clk); #1;
      chk(bit_vld == ev, req, bit_vld, ev);
      if (ev) chk(bit_out == b, req, bit_out, b);
      if (!on) chk(bit_out == 1'b0, "R6", bit_out, 0);
      if (bit_vld) nv++;
    end
    dsd_req = 1'b1;
    chk(code_err == m_err, "R4", code_err, m_err);
    if (drop < 0) chk(nv == 1, "R7", nv, 1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dsd_clk = 1'b0; bit_clk = 1'b0;
      @(posedge clk); #1;
    end
  endtask

  task automatic set_fmt(input bit f);
    @(negedge clk);
    if (f != fmt_bi) begin m_half_ok = 1'b0; m_err = 1'b0; end
    fmt_bi = f; dsd_clk = 1'b0; bit_clk = 1'b0;
    @(posedge clk); #1;
    idle(1);
  endtask

  task automatic t_reset();
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk(bit_vld == 1'b0, "R8", bit_vld, 0);
    chk(bit_out == 1'b0, "R8", bit_out, 0);
    chk(code_err == 1'b0, "R8", code_err, 0);
  endtask

  task automatic t_mono();
    set_fmt(1'b0);
    period(1'b1, -1, 1'b0, "R2");
    period(1'b0, -1, 1'b0, "R2");
    period(1'b1, -1, 1'b0, "R2");
    period(1'b1, -1, 1'b0, "R7");
  endtask

  task automatic t_off(input bit ms, input bit rq);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      mode_sel = ms; dsd_req = rq;
      dsd_clk = (i < 4); bit_clk = ((i % 4) < 2); din = 1'b1;
      @(posedge clk); #1;
      chk(bit_vld == 1'b0, "R1", bit_vld, 0);
      chk(bit_out == 1'b0, "R1", bit_out, 0);
    end
    @(negedge clk);
    mode_sel = 1'b0; dsd_req = 1'b1;
    m_half_ok = 1'b0; m_err = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic t_bi();
    set_fmt(1'b1);
    period(1'b1, -1, 1'b0, "R3");
    period(1'b0, -1, 1'b0, "R3");
    period(1'b0, -1, 1'b0, "R3");
    period(1'b1, -1, 1'b0, "R7");
  endtask

  task automatic t_err();
    period(1'b1, -1, 1'b1, "R4");
    chk(code_err == 1'b1, "R4", code_err, 1);
    period(1'b0, -1, 1'b0, "R4");
    chk(code_err == 1'b1, "R4", code_err, 1);
    set_fmt(1'b0);
    chk(code_err == 1'b0, "R5", code_err, 0);
    set_fmt(1'b1);
    period(1'b1, -1, 1'b0, "R5");
  endtask

  task automatic t_drop();
    period(1'b0, -1, 1'b1, "R4");
    period(1'b1, 4, 1'b0, "R6");
    chk(code_err == 1'b0, "R6", code_err, 0);
    period(1'b0, -1, 1'b0, "R6");
  endtask

  initial begin
    t_reset();
    t_mono();
    t_off(1'b1, 1'b1);
    t_off(1'b0, 1'b0);
    t_off(1'b1, 1'b0);
    period(1'b1, -1, 1'b0, "R1");
    t_bi();
    t_err();
    t_drop();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule